// File: doc/BRIEF.md
# Software-Triggered Flash Command Engine

This block runs one short serial-flash command at a time. A host programs a single 32-bit command word that packs the opcode, the phase enables and the phase lengths. It also loads an address register and a pair of write-payload words, then sets the execute bit in the command word. The engine walks the frame one byte item at a time over a generic byte-serial sequencer interface. The order is opcode, address, dummy clocks, then either a write payload or a read payload. Chip select stays asserted for the whole frame.

While the frame runs, the in-progress bit of the command word reads as one. When it clears, the host collects up to eight received bytes from two 32-bit read-data words. The first received byte sits in the lowest byte lane. Payload and address lengths are held as length minus one.

The sequencer interface carries one item at a time. The engine presents `seq_valid` with a kind code and a send byte, and holds them until the sequencer pulses `seq_done`. For a receive item, the sequencer returns the byte on `seq_rx` in the same cycle as `seq_done`.

Top module: `flash_cmd_engine`

## Requirements
- R1: After reset `seq_cs_n` is 1, `seq_valid` is 0, the in-progress bit (bit 1 of the command word read at select 0) is 0 and both read-data words read 0.
- R2: A register write to select 0 with bit 0 set while idle starts a frame. From the next cycle `seq_valid` is 1 and bit 1 of select 0 reads 1. The first item is a send (kind 0) of bits 31:24 of the written word.
- R3: If bit 19 is set, the opcode is followed by address send items. Their count is bits 17:16 plus one (1 to 4), and they carry the address register (select 1) most significant byte first, ending with bits 7:0. Dummy-clock items (kind 2) follow, as many as bits 11:7 give (0 means none).
- R4: If bit 15 is set, the frame ends with bits 14:12 plus one send items. Item i carries byte lane i of {write-high (select 3), write-low (select 2)}, lane 0 being bits 7:0 of write-low.
- R5: If bit 23 is set, the frame ends with bits 22:20 plus one receive items (kind 1). The i-th received byte lands in byte lane i of {read-high (select 5), read-low (select 4)}. Lanes not received in the latest frame read 0.
- R6: If bits 15 and 23 are both set, only the opcode item is sent, whatever the other enables are.
- R7: A write to select 0 while the in-progress bit is 1 is ignored: the running frame is unchanged and no new frame starts. The command word read back keeps its previous contents.
- R8: `seq_cs_n` is 0 whenever `seq_valid` is 1. A presented item holds its kind and byte until `seq_done`. Once the final item completes, `seq_cs_n` returns to 1 and the in-progress bit to 0 on the next cycle.
- R9: Selects 1, 2 and 3 read back the value last written. Unused selects (6, 7) read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 32 | Register write data |
| rd_sel | input | 3 | Register select for the read |
| rd_data | output | 32 | Read data for the selected register |
| seq_valid | output | 1 | An item is presented to the sequencer |
| seq_kind | output | 2 | Item kind: 0 send, 1 receive, 2 dummy clock |
| seq_tx | output | 8 | Byte to send for a send item |
| seq_cs_n | output | 1 | Chip select, active low, held for the frame |
| seq_done | input | 1 | Sequencer finished the presented item |
| seq_rx | input | 8 | Received byte, valid with seq_done on a receive item |

## Verification
The bench builds the engine with its default values: eight payload bytes and clearing of read lanes at each execute. This makes the full eight-byte read and write reachable across both data words. It also allows the longest 31-item dummy phase. The bench shows zero-filled lanes by running a short read after a long one. The sequencer model answers every item after a one-cycle pause, so each held item can be checked. That pause also leaves room to issue a second execute in the middle of a frame.

// File: rtl/fce_pkg.sv
package fce_pkg;
   localparam int REG_W   = 32;
   localparam int SEL_W   = 3;
   localparam int DUMMY_W = 5;
   localparam int CNT_W   = 5;

   localparam logic [1:0] K_SEND  = 2'd0;
   localparam logic [1:0] K_RECV  = 2'd1;
   localparam logic [1:0] K_DUMMY = 2'd2;

   localparam logic [SEL_W-1:0] S_CMD  = 3'd0;
   localparam logic [SEL_W-1:0] S_ADDR = 3'd1;
   localparam logic [SEL_W-1:0] S_WLO  = 3'd2;
   localparam logic [SEL_W-1:0] S_WHI  = 3'd3;
   localparam logic [SEL_W-1:0] S_RLO  = 3'd4;
   localparam logic [SEL_W-1:0] S_RHI  = 3'd5;

   typedef enum logic [2:0] {
      PH_IDLE, PH_OPC, PH_ADR, PH_DMY, PH_WR, PH_RD
   } phase_t;

   typedef struct packed {
      logic [7:0]         opc;
      logic               ren;
      logic [2:0]         rcnt;
      logic               aen;
      logic [1:0]         acnt;
      logic               wen;
      logic [2:0]         wcnt;
      logic [DUMMY_W-1:0] dmy;
   } cmd_t;

   function automatic cmd_t unpack_cmd(input logic [REG_W-1:0] w);
      cmd_t c;
      c.opc  = w[31:24];
      c.ren  = w[23];
      c.rcnt = w[22:20];
      c.aen  = w[19];
      c.acnt = w[17:16];
      c.wen  = w[15];
      c.wcnt = w[14:12];
      c.dmy  = w[11:7];
      return c;
   endfunction
endpackage

// File: rtl/fce_regs.sv
module fce_regs
   import fce_pkg::*;
#(
   parameter int DATA_BYTES = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [SEL_W-1:0]        wr_sel,
   input  logic [REG_W-1:0]        wr_data,
   input  logic [SEL_W-1:0]        rd_sel,
   output logic [REG_W-1:0]        rd_data,
   input  logic                    busy,
   input  logic [2*REG_W-1:0]      rx_data,
   output logic                    start,
   output cmd_t                    cmd,
   output logic [REG_W-1:0]        addr,
   output logic [8*DATA_BYTES-1:0] wdata
);
   logic [REG_W-1:2]   ctrl_q;
   logic [2*REG_W-1:0] wd_q;
   logic               cmd_wr;

   assign cmd_wr = wr_en && (wr_sel == S_CMD) && !busy;
   assign start  = cmd_wr && wr_data[0];
   assign cmd    = unpack_cmd({ctrl_q, 2'b00});
   assign wdata  = wd_q[8*DATA_BYTES-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         addr   <= '0;
         wd_q   <= '0;
      end else if (wr_en) begin
         if (cmd_wr)              ctrl_q <= wr_data[REG_W-1:2];
         if (wr_sel == S_ADDR)    addr   <= wr_data;
         if (wr_sel == S_WLO)     wd_q[REG_W-1:0] <= wr_data;
         if (wr_sel == S_WHI)     wd_q[2*REG_W-1:REG_W] <= wr_data;
      end
   end

   always_comb begin
      case (rd_sel)
         S_CMD:   rd_data = {ctrl_q, busy, 1'b0};
         S_ADDR:  rd_data = addr;
         S_WLO:   rd_data = wd_q[REG_W-1:0];
         S_WHI:   rd_data = wd_q[2*REG_W-1:REG_W];
         S_RLO:   rd_data = rx_data[REG_W-1:0];
         S_RHI:   rd_data = rx_data[2*REG_W-1:REG_W];
         default: rd_data = '0;
      endcase
   end
endmodule

// File: rtl/fce_frame.sv
module fce_frame
   import fce_pkg::*;
#(
   parameter int DATA_BYTES = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  cmd_t                    cmd,
   input  logic [REG_W-1:0]        addr,
   input  logic [8*DATA_BYTES-1:0] wdata,
   input  logic                    seq_done,
   output logic                    seq_valid,
   output logic [1:0]              seq_kind,
   output logic [7:0]              seq_tx,
   output logic                    seq_cs_n,
   output logic                    busy,
   output logic                    rx_we,
   output logic [2:0]              rx_idx
);
   phase_t            ph, ph_nxt;
   logic [CNT_W-1:0]  cnt, last;
   logic              clash, early;
   logic [1:0]        adiff;
   logic [REG_W-1:0]  ash;
   logic [8*DATA_BYTES-1:0] wsh;

   assign clash = cmd.wen && cmd.ren;
   assign early = (ph == PH_OPC) || (ph == PH_ADR) || (ph == PH_DMY);

   always_comb begin
      ph_nxt = PH_IDLE;
      if (!clash) begin
         if (ph == PH_OPC && cmd.aen)
            ph_nxt = PH_ADR;
         else if ((ph == PH_OPC || ph == PH_ADR) && cmd.dmy != '0)
            ph_nxt = PH_DMY;
         else if (early && cmd.wen)
            ph_nxt = PH_WR;
         else if (early && cmd.ren)
            ph_nxt = PH_RD;
      end
   end

   always_comb begin
      case (ph)
         PH_ADR:  last = {3'b000, cmd.acnt};
         PH_DMY:  last = cmd.dmy - 5'd1;
         PH_WR:   last = {2'b00, cmd.wcnt};
         PH_RD:   last = {2'b00, cmd.rcnt};
         default: last = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph  <= PH_IDLE;
         cnt <= '0;
      end else if (start) begin
         ph  <= PH_OPC;
         cnt <= '0;
      end else if (ph != PH_IDLE && seq_done) begin
         if (cnt == last) begin
            ph  <= ph_nxt;
            cnt <= '0;
         end else begin
            cnt <= cnt + 5'd1;
         end
      end
   end

   assign adiff = cmd.acnt - cnt[1:0];
   assign ash   = addr >> {adiff, 3'b000};
   assign wsh   = wdata >> {cnt[2:0], 3'b000};

   always_comb begin
      case (ph)
         PH_OPC:  seq_tx = cmd.opc;
         PH_ADR:  seq_tx = ash[7:0];
         PH_WR:   seq_tx = wsh[7:0];
         default: seq_tx = 8'h00;
      endcase
      case (ph)
         PH_RD:   seq_kind = K_RECV;
         PH_DMY:  seq_kind = K_DUMMY;
         default: seq_kind = K_SEND;
      endcase
   end

   assign busy      = (ph != PH_IDLE);
   assign seq_valid = busy;
   assign seq_cs_n  = !busy;
   assign rx_we     = (ph == PH_RD) && seq_done;
   assign rx_idx    = cnt[2:0];
endmodule

// File: rtl/fce_rx_pack.sv
module fce_rx_pack
   import fce_pkg::*;
#(
   parameter int DATA_BYTES = 8,
   parameter bit CLEAR_RX   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               we,
   input  logic [2:0]         idx,
   input  logic [7:0]         din,
   output logic [2*REG_W-1:0] rx_data
);
   for (genvar i = 0; i < DATA_BYTES; i++) begin : g_lane
      logic [7:0] lane_q;
      if (CLEAR_RX) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     lane_q <= '0;
            else if (clr)                   lane_q <= '0;
            else if (we && idx == 3'(i))    lane_q <= din;
         end
      end else begin : g_keep
         logic unused_clr;
         assign unused_clr = clr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     lane_q <= '0;
            else if (we && idx == 3'(i))    lane_q <= din;
         end
      end
      assign rx_data[8*i +: 8] = lane_q;
   end

   if (DATA_BYTES < 8) begin : g_pad
      assign rx_data[2*REG_W-1:8*DATA_BYTES] = '0;
   end
endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
   import fce_pkg::*;
#(
   parameter int DATA_BYTES = 8,
   parameter bit CLEAR_RX   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [2:0]       wr_sel,
   input  logic [31:0]      wr_data,
   input  logic [2:0]       rd_sel,
   output logic [31:0]      rd_data,
   output logic             seq_valid,
   output logic [1:0]       seq_kind,
   output logic [7:0]       seq_tx,
   output logic             seq_cs_n,
   input  logic             seq_done,
   input  logic [7:0]       seq_rx
);
   initial begin
      if (DATA_BYTES != 4 && DATA_BYTES != 8)
         $error("DATA_BYTES must be 4 or 8");
   end

   logic                    start, busy, rx_we;
   logic [2:0]              rx_idx;
   cmd_t                    cmd;
   logic [REG_W-1:0]        addr;
   logic [8*DATA_BYTES-1:0] wdata;
   logic [2*REG_W-1:0]      rx_data;

   fce_regs #(.DATA_BYTES(DATA_BYTES)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
      .busy(busy), .rx_data(rx_data), .start(start), .cmd(cmd),
      .addr(addr), .wdata(wdata)
   );

   fce_frame #(.DATA_BYTES(DATA_BYTES)) u_frame (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd),
      .addr(addr), .wdata(wdata), .seq_done(seq_done),
      .seq_valid(seq_valid), .seq_kind(seq_kind), .seq_tx(seq_tx),
      .seq_cs_n(seq_cs_n), .busy(busy), .rx_we(rx_we), .rx_idx(rx_idx)
   );

   fce_rx_pack #(.DATA_BYTES(DATA_BYTES), .CLEAR_RX(CLEAR_RX)) u_rx (
      .clk(clk), .rst_n(rst_n), .clr(start), .we(rx_we),
      .idx(rx_idx), .din(seq_rx), .rx_data(rx_data)
   );
endmodule

// File: rtl/fce_chk.sv
module fce_chk
   import fce_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic [2:0]  wr_sel,
   input logic [31:0] wr_data,
   input logic        busy,
   input cmd_t        cmd,
   input logic        seq_valid,
   input logic [1:0]  seq_kind,
   input logic [7:0]  seq_tx,
   input logic        seq_cs_n,
   input logic        seq_done
);
   logic go;
   assign go = wr_en && wr_sel == S_CMD && wr_data[0] && !busy;

   a_r2_exec_opcode: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> seq_valid && seq_kind == K_SEND && seq_tx == $past(wr_data[31:24]));

   a_r7_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == S_CMD && busy) |=> $stable(cmd));

   a_r6_clash_opcode_only: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_valid && seq_done && cmd.wen && cmd.ren) |=> seq_cs_n);

   a_r8_item_held: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_valid && !seq_done) |=> seq_valid && $stable(seq_tx) && $stable(seq_kind));

   a_r8_release_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(seq_cs_n) |-> $past(seq_valid && seq_done));

   a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      seq_cs_n |-> !seq_valid);
endmodule

bind flash_cmd_engine fce_chk u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
   .wr_data(wr_data), .busy(busy), .cmd(cmd), .seq_valid(seq_valid),
   .seq_kind(seq_kind), .seq_tx(seq_tx), .seq_cs_n(seq_cs_n),
   .seq_done(seq_done)
);

// File: tb/sim_flash_cmd_engine.sv
module sim_flash_cmd_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_sel = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  rd_sel = '0;
   logic [31:0] rd_data;
   logic        seq_valid, seq_cs_n;
   logic [1:0]  seq_kind;
   logic [7:0]  seq_tx;
   logic        seq_done = 1'b0;
   logic [7:0]  seq_rx = '0;

   int checks = 0;
   int errors = 0;
   logic [9:0] exp_q[$];

   always #5 clk = ~clk;

   flash_cmd_engine u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
      .seq_valid(seq_valid), .seq_kind(seq_kind), .seq_tx(seq_tx),
      .seq_cs_n(seq_cs_n), .seq_done(seq_done), .seq_rx(seq_rx)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   function automatic logic [31:0] mk(input logic [7:0] opc, input logic ren,
         input logic [2:0] rcnt, input logic aen, input logic [1:0] acnt,
         input logic wen, input logic [2:0] wcnt, input logic [4:0] dmy);
      return {opc, ren, rcnt, aen, 1'b0, acnt, wen, wcnt, dmy, 5'b0, 1'b0, 1'b1};
   endfunction

   task automatic push(input logic [1:0] k, input logic [7:0] b);
      exp_q.push_back({k, b});
   endtask

   task automatic wreg(input logic [2:0] s, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = s; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rreg(input logic [2:0] s, output logic [31:0] v);
      rd_sel = s;
      #1;
      v = rd_data;
   endtask

   task automatic wait_idle(input string tag);
      logic [31:0] v;
      int quiet = 0;
      while (quiet < 3) begin
         @(negedge clk);
         rreg(3'd0, v);
         quiet = v[1] ? 0 : quiet + 1;
      end
      chk({tag, " R8 cs released"}, 64'(seq_cs_n), 64'd1);
      chk({tag, " R3 all items seen"}, 64'(exp_q.size()), 64'd0);
   endtask

   task automatic run(input string tag, input logic [31:0] c);
      logic [31:0] v;
      wreg(3'd0, c);
      rreg(3'd0, v);
      chk({tag, " R2 busy set"}, 64'(v[1]), 64'd1);
      chk({tag, " R8 cs asserted"}, 64'(seq_cs_n), 64'd0);
      wait_idle(tag);
   endtask

   // sequencer model and scoreboard monitor
   initial begin
      int wait_c = 0;
      int rx_i = 0;
      logic [9:0] e;
      forever begin
         @(negedge clk);
         seq_done = 1'b0;
         if (seq_cs_n) rx_i = 0;
         if (seq_valid) begin
            if (wait_c > 0) begin
               wait_c--;
            end else begin
               chk("R8 cs low with item", 64'(seq_cs_n), 64'd0);
               if (exp_q.size() == 0) begin
                  chk("R3 unexpected item", 64'({seq_kind, seq_tx}), 64'h3ff);
               end else begin
                  e = exp_q.pop_front();
                  chk("R3 item kind", 64'(seq_kind), 64'(e[9:8]));
                  if (e[9:8] == 2'd0)
                     chk("R4 item byte", 64'(seq_tx), 64'(e[7:0]));
               end
               if (seq_kind == 2'd1) begin
                  seq_rx = 8'hA0 + 8'(rx_i);
                  rx_i++;
               end
               seq_done = 1'b1;
               wait_c = 1;
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      chk("watchdog expired", 64'd1, 64'd0);
      summary();
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 cs_n", 64'(seq_cs_n), 64'd1);
      chk("R1 valid", 64'(seq_valid), 64'd0);
      rreg(3'd0, v); chk("R1 busy", 64'(v[1]), 64'd0);
      rreg(3'd4, v); chk("R1 rdata lo", 64'(v), 64'd0);
      rreg(3'd5, v); chk("R1 rdata hi", 64'(v), 64'd0);

      // R9 register readback
      wreg(3'd1, 32'h00123456);
      wreg(3'd2, 32'h44332211);
      wreg(3'd3, 32'h00000055);
      rreg(3'd1, v); chk("R9 addr", 64'(v), 64'h00123456);
      rreg(3'd2, v); chk("R9 wlo", 64'(v), 64'h44332211);
      rreg(3'd3, v); chk("R9 whi", 64'(v), 64'h00000055);
      rreg(3'd6, v); chk("R9 unused sel", 64'(v), 64'd0);

      // R2 opcode only
      push(2'd0, 8'h06);
      run("R2 opc", mk(8'h06, 0, 0, 0, 0, 0, 0, 0));

      // R3 R5: 3-byte address, 8 dummy, 8 read bytes
      push(2'd0, 8'h0B);
      push(2'd0, 8'h12); push(2'd0, 8'h34); push(2'd0, 8'h56);
      for (int i = 0; i < 8; i++) push(2'd2, 8'h00);
      for (int i = 0; i < 8; i++) push(2'd1, 8'h00);
      run("R3 read8", mk(8'h0B, 1, 7, 1, 2, 0, 0, 8));
      rreg(3'd4, v); chk("R5 rdata lo", 64'(v), 64'hA3A2A1A0);
      rreg(3'd5, v); chk("R5 rdata hi", 64'(v), 64'hA7A6A5A4);

      // R5 short read clears unused lanes
      push(2'd0, 8'h9F);
      for (int i = 0; i < 3; i++) push(2'd1, 8'h00);
      run("R5 read3", mk(8'h9F, 1, 2, 0, 0, 0, 0, 0));
      rreg(3'd4, v); chk("R5 short lo", 64'(v), 64'h00A2A1A0);
      rreg(3'd5, v); chk("R5 short hi", 64'(v), 64'h0);

      // R4 write 5 bytes after 4-byte address
      wreg(3'd1, 32'hDEADBEEF);
      push(2'd0, 8'h12);
      push(2'd0, 8'hDE); push(2'd0, 8'hAD); push(2'd0, 8'hBE); push(2'd0, 8'hEF);
      push(2'd0, 8'h11); push(2'd0, 8'h22); push(2'd0, 8'h33);
      push(2'd0, 8'h44); push(2'd0, 8'h55);
      run("R4 write5", mk(8'h12, 0, 0, 1, 3, 1, 4, 0));

      // R3 one-byte address
      wreg(3'd1, 32'h000000AB);
      push(2'd0, 8'h20); push(2'd0, 8'hAB);
      run("R3 addr1", mk(8'h20, 0, 0, 1, 0, 0, 0, 0));

      // R3 longest dummy phase
      push(2'd0, 8'h5A);
      for (int i = 0; i < 31; i++) push(2'd2, 8'h00);
      run("R3 dummy31", mk(8'h5A, 0, 0, 0, 0, 0, 0, 31));

      // R6 read and write together: opcode only
      push(2'd0, 8'h77);
      run("R6 clash", mk(8'h77, 1, 7, 1, 3, 1, 7, 4));
      rreg(3'd4, v); chk("R6 nothing received", 64'(v), 64'h0);

      // R7 execute while busy is ignored
      push(2'd0, 8'h3B);
      for (int i = 0; i < 4; i++) push(2'd2, 8'h00);
      for (int i = 0; i < 2; i++) push(2'd1, 8'h00);
      wreg(3'd0, mk(8'h3B, 1, 1, 0, 0, 0, 0, 4));
      wreg(3'd0, mk(8'hC7, 0, 0, 0, 0, 1, 7, 0));
      wait_idle("R7 busy write");
      rreg(3'd0, v); chk("R7 ctrl unchanged", 64'(v[31:24]), 64'h3B);
      rreg(3'd4, v); chk("R7 frame data", 64'(v), 64'h0000A1A0);

      summary();
   end
endmodule